// File: doc/BRIEF.md
# Audio Stream DMA Control Registers

This block holds the register set that software uses to program one direction of an audio memory-transfer engine, and it tracks where that engine is inside its ring buffer. Software sets the buffer base address, the sample width, the number of active channels, the period size and the period count. It also sets the enables and can start a self-timed soft reset. A read-only capability word tells software which directions, channel limits and packing modes the core was built with.

The data mover is modelled by a single-cycle transfer strobe. Each accepted strobe moves a byte position forward by one sample's worth of bytes. When the position reaches the end of a period, the block sets a sticky completion flag that software clears by writing one to it. When the position reaches the end of the last period, it returns to zero. The interrupt output is the completion flag gated by its enable bit. Writes are single-cycle. Reads are combinational from the address.

The bank decodes offsets inside a 256-byte window selected by the `BANK_SEL` parameter (bank 0 at 0x000, bank 1 at 0x100). Addresses outside the window read zero.

Top module: `adma_stream_regs`

## Requirements
- R1: After reset, control (0x10), status (0x14) and position (0x28) read 0, and `irq_o` is low.
- R2: Offset 0x04 returns the capability word, and writes to it have no effect. Its fields are:
  - bit 15: read direction present.
  - bit 31: write direction present.
  - bits 11:8 and 27:24: maximum channel counts.
  - bits 14:13 and 30:29: conversion mode.
  - bits 12 and 28: non-interleaved packing.
  - With the default parameters the word is 0x0000C200.
- R3: These registers read back what was written, to the width stated:
  - 0x18: frame-rate multiplier, 32 bits.
  - 0x1C: period configuration, with the period count in bits 19:16 and the period bytes in bits 15:0.
  - 0x20 and 0x24: buffer address low and high, 32 bits each.
  - 0x44: bytes per channel, 32 bits.
- R4: These reads return 0:
  - offsets in the bank that have no register;
  - any address outside the bank's 256-byte window.
- R5: The sample-width code is in control bits 18:16. Code 0 gives 1 byte per sample, code 1 gives 2 bytes, and codes 2, 3, 4 (and above) give 4 bytes. While control bit 0 (enable) is set, each transfer strobe adds that byte count to the position.
- R6: A transfer strobe does not change the position while the enable bit is clear.
- R7: When the position reaches a multiple of the period bytes, status bit 31 is set in the same cycle as that position update.
- R8: `irq_o` is high exactly when status bit 31 and control bit 13 are both set.
- R9: Writing 1 to status bit 31 clears it. Writing 0 to it leaves it set.
- R10: When the position reaches period bytes × period count, it wraps to 0.
- R11: While the enable bit is set, writes to the period configuration and to the width field are ignored.
- R12: Writing 1 to control bit 1 starts a soft reset, and control bit 1 reads 1 for exactly 8 cycles. During the reset the block clears the enable bit, the position and status bit 31.
- R13: Status bit 29 reflects the `chsts_vld_i` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (12) | Byte address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| xfer_i | input | 1 | One-cycle transfer strobe from the data mover |
| chsts_vld_i | input | 1 | Channel-status data valid |
| irq_o | output | 1 | Period-completion interrupt |

## Verification
The hardest state to reach is the ring wrap. It only happens after the period offset and the period index have both rolled over together, so the bench programs a 192-byte, two-period ring at 4 bytes per sample. It then drives exactly 47, 48 and 96 strobes, so that the position lands one sample short of the first boundary, on the boundary, and on the wrap. The soft-reset window is measured by polling control bit 1 every cycle from the write onward. The configuration lock is probed by writing new period and width values while transfers run and then reading them back.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam logic [7:0] OFF_CAP   = 8'h04;
  localparam logic [7:0] OFF_CTRL  = 8'h10;
  localparam logic [7:0] OFF_STS   = 8'h14;
  localparam logic [7:0] OFF_FSMUL = 8'h18;
  localparam logic [7:0] OFF_PCFG  = 8'h1C;
  localparam logic [7:0] OFF_ADRLO = 8'h20;
  localparam logic [7:0] OFF_ADRHI = 8'h24;
  localparam logic [7:0] OFF_POS   = 8'h28;
  localparam logic [7:0] OFF_BPC   = 8'h44;

  typedef struct packed {
    logic [3:0] chans;
    logic [2:0] width;
    logic       tout_ie;
    logic       ioc_ie;
    logic       srst;
    logic       en;
  } ctrl_t;

  typedef struct packed {
    logic [3:0]  periods;
    logic [15:0] pbytes;
  } pcfg_t;

  function automatic logic [2:0] width_bytes(input logic [2:0] code);
    case (code)
      3'd0:    width_bytes = 3'd1;
      3'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/adma_regs.sv
module adma_regs
  import adma_pkg::*;
#(
  parameter int RST_CYCLES = 8,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  off_i,
  input  logic [31:0] wdata_i,
  input  logic        tick_i,
  output ctrl_t       ctrl_o,
  output pcfg_t       pcfg_o,
  output logic        done_o,
  output logic [31:0] fsmul_o,
  output logic [31:0] adrlo_o,
  output logic [31:0] adrhi_o,
  output logic [31:0] bpc_o
);
  ctrl_t   ctrl_q;
  pcfg_t   pcfg_q;
  logic    done_q;
  logic [CW-1:0] cnt_q;
  logic    wr_ctrl, wr_sts;

  assign wr_ctrl = wr_i && (off_i == OFF_CTRL);
  assign wr_sts  = wr_i && (off_i == OFF_STS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      pcfg_q  <= '0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      fsmul_o <= '0;
      adrlo_o <= '0;
      adrhi_o <= '0;
      bpc_o   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en      <= wdata_i[0] & ~wdata_i[1];
        ctrl_q.ioc_ie  <= wdata_i[13];
        ctrl_q.tout_ie <= wdata_i[14];
        ctrl_q.chans   <= wdata_i[22:19];
        if (!ctrl_q.en) ctrl_q.width <= wdata_i[18:16];
        if (wdata_i[1]) begin
          ctrl_q.srst <= 1'b1;
          cnt_q       <= CW'(RST_CYCLES - 1);
        end
      end
      if (wr_i && off_i == OFF_PCFG && !ctrl_q.en) begin
        pcfg_q.periods <= wdata_i[19:16];
        pcfg_q.pbytes  <= wdata_i[15:0];
      end
      if (wr_i && off_i == OFF_FSMUL) fsmul_o <= wdata_i;
      if (wr_i && off_i == OFF_ADRLO) adrlo_o <= wdata_i;
      if (wr_i && off_i == OFF_ADRHI) adrhi_o <= wdata_i;
      if (wr_i && off_i == OFF_BPC)   bpc_o   <= wdata_i;
      // set wins over a same-cycle clear
      if (tick_i)                       done_q <= 1'b1;
      else if (wr_sts && wdata_i[31])   done_q <= 1'b0;
      if (ctrl_q.srst) begin
        ctrl_q.en <= 1'b0;
        done_q    <= 1'b0;
        if (cnt_q == '0) ctrl_q.srst <= 1'b0;
        else             cnt_q       <= cnt_q - 1'b1;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign pcfg_o = pcfg_q;
  assign done_o = done_q;

  // R12
  srst_blocks_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.srst |-> !ctrl_q.en);
  // R7
  done_from_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(tick_i));
  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !wr_sts && !ctrl_q.srst) |=> done_q);
  // R11
  width_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_q.en) |-> $stable(ctrl_q.width));
endmodule

// File: rtl/adma_pos.sv
module adma_pos
  import adma_pkg::*;
#(
  parameter int POS_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [2:0]       bps_i,
  input  pcfg_t            pcfg_i,
  output logic [POS_W-1:0] pos_o,
  output logic             tick_o
);
  logic [15:0]      poff_q;
  logic [3:0]       pidx_q;
  logic [POS_W-1:0] pos_q;
  logic [16:0]      poff_nx;
  logic             end_p, last_p;

  assign poff_nx = {1'b0, poff_q} + 17'(bps_i);
  assign end_p   = poff_nx >= {1'b0, pcfg_i.pbytes};
  assign last_p  = ({1'b0, pidx_q} + 5'd1) >= {1'b0, pcfg_i.periods};
  assign tick_o  = step_i && !clr_i && end_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poff_q <= '0;
      pidx_q <= '0;
      pos_q  <= '0;
    end else if (clr_i) begin
      poff_q <= '0;
      pidx_q <= '0;
      pos_q  <= '0;
    end else if (step_i) begin
      if (end_p) begin
        poff_q <= '0;
        if (last_p) begin
          pidx_q <= '0;
          pos_q  <= '0;
        end else begin
          pidx_q <= pidx_q + 4'd1;
          pos_q  <= pos_q + POS_W'(bps_i);
        end
      end else begin
        poff_q <= poff_nx[15:0];
        pos_q  <= pos_q + POS_W'(bps_i);
      end
    end
  end

  assign pos_o = pos_q;

  // R6
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(pos_q));
  // R12
  pos_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pos_q == '0));
endmodule

// File: rtl/adma_rdmux.sv
module adma_rdmux
  import adma_pkg::*;
#(
  parameter int POS_W = 20
) (
  input  logic             hit_i,
  input  logic [7:0]       off_i,
  input  logic [31:0]      cap_i,
  input  ctrl_t            ctrl_i,
  input  logic             done_i,
  input  logic             chsts_i,
  input  logic [31:0]      fsmul_i,
  input  pcfg_t            pcfg_i,
  input  logic [31:0]      adrlo_i,
  input  logic [31:0]      adrhi_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [31:0]      bpc_i,
  output logic [31:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      case (off_i)
        OFF_CAP:   rdata_o = cap_i;
        OFF_CTRL:  rdata_o = {9'b0, ctrl_i.chans, ctrl_i.width, 1'b0,
                              ctrl_i.tout_ie, ctrl_i.ioc_ie, 11'b0,
                              ctrl_i.srst, ctrl_i.en};
        OFF_STS:   rdata_o = {done_i, 1'b0, chsts_i, 29'b0};
        OFF_FSMUL: rdata_o = fsmul_i;
        OFF_PCFG:  rdata_o = {12'b0, pcfg_i.periods, pcfg_i.pbytes};
        OFF_ADRLO: rdata_o = adrlo_i;
        OFF_ADRHI: rdata_o = adrhi_i;
        OFF_POS:   rdata_o = 32'(pos_i);
        OFF_BPC:   rdata_o = bpc_i;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/adma_stream_regs.sv
module adma_stream_regs
  import adma_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          POS_W      = 20,
  parameter int          RST_CYCLES = 8,
  parameter int          BANK_SEL   = 0,
  parameter bit          HAS_RD     = 1'b1,
  parameter bit          HAS_WR     = 1'b0,
  parameter logic [3:0]  MAXCH_RD   = 4'd2,
  parameter logic [3:0]  MAXCH_WR   = 4'd0,
  parameter logic [1:0]  MODE_RD    = 2'd2,
  parameter logic [1:0]  MODE_WR    = 2'd0,
  parameter bit          NONINT_RD  = 1'b0,
  parameter bit          NONINT_WR  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              xfer_i,
  input  logic              chsts_vld_i,
  output logic              irq_o
);
  localparam logic [31:0] CAP = {HAS_WR, MODE_WR, NONINT_WR, MAXCH_WR, 8'b0,
                                 HAS_RD, MODE_RD, NONINT_RD, MAXCH_RD, 8'b0};

  logic        hit;
  logic [7:0]  off;
  ctrl_t       ctrl;
  pcfg_t       pcfg;
  logic        done, tick, step;
  logic [31:0] fsmul, adrlo, adrhi, bpc;
  logic [POS_W-1:0] pos;

  assign hit  = (addr_i[ADDR_W-1:8] == (ADDR_W-8)'(BANK_SEL));
  assign off  = addr_i[7:0];
  assign step = xfer_i && ctrl.en && !ctrl.srst;

  adma_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr_i && hit), .off_i(off), .wdata_i,
    .tick_i(tick), .ctrl_o(ctrl), .pcfg_o(pcfg), .done_o(done),
    .fsmul_o(fsmul), .adrlo_o(adrlo), .adrhi_o(adrhi), .bpc_o(bpc)
  );

  adma_pos #(.POS_W(POS_W)) u_pos (
    .clk_i, .rst_ni, .clr_i(ctrl.srst), .step_i(step),
    .bps_i(width_bytes(ctrl.width)), .pcfg_i(pcfg), .pos_o(pos), .tick_o(tick)
  );

  adma_rdmux #(.POS_W(POS_W)) u_rd (
    .hit_i(hit), .off_i(off), .cap_i(CAP), .ctrl_i(ctrl), .done_i(done),
    .chsts_i(chsts_vld_i), .fsmul_i(fsmul), .pcfg_i(pcfg), .adrlo_i(adrlo),
    .adrhi_i(adrhi), .pos_i(pos), .bpc_i(bpc), .rdata_o(rdata_o)
  );

  assign irq_o = done && ctrl.ioc_ie;

  // R8
  irq_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdata_o[31] || off != OFF_STS || !hit));
endmodule

// File: tb/sim_adma_stream_regs.sv
`timescale 1ns/1ps
module sim_adma_stream_regs;
  logic        clk = 0, rst_n = 0;
  logic        wr = 0, xfer = 0, chsts = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  adma_stream_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .xfer_i(xfer), .chsts_vld_i(chsts), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xfer = 1;
      @(negedge clk); xfer = 0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(12'h010, d); chk("R1 ctrl", d, 0);
    rd_reg(12'h014, d); chk("R1 sts", d, 0);
    rd_reg(12'h028, d); chk("R1 pos", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_cap;
    logic [31:0] d;
    rd_reg(12'h004, d); chk("R2 cap", d, 32'h0000_C200);
    wr_reg(12'h004, 32'hFFFF_FFFF);
    rd_reg(12'h004, d); chk("R2 cap after write", d, 32'h0000_C200);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr_reg(12'h018, 32'h0000_0100);
    wr_reg(12'h020, 32'hDEAD_BEC0);
    wr_reg(12'h024, 32'h0000_0012);
    wr_reg(12'h044, 32'h0000_0060);
    wr_reg(12'h01C, 32'h0002_00C0);
    rd_reg(12'h018, d); chk("R3 fsmul", d, 32'h0000_0100);
    rd_reg(12'h020, d); chk("R3 adr lo", d, 32'hDEAD_BEC0);
    rd_reg(12'h024, d); chk("R3 adr hi", d, 32'h0000_0012);
    rd_reg(12'h044, d); chk("R3 bpc", d, 32'h0000_0060);
    rd_reg(12'h01C, d); chk("R3 pcfg", d, 32'h0002_00C0);
  endtask

  task automatic t_undef;
    logic [31:0] d;
    rd_reg(12'h030, d); chk("R4 hole", d, 0);
    rd_reg(12'h104, d); chk("R4 other bank cap", d, 0);
    rd_reg(12'h11C, d); chk("R4 other bank pcfg", d, 0);
  endtask

  task automatic t_step;
    logic [31:0] d;
    wr_reg(12'h010, 32'h0001_0001);       // en, 2-byte samples
    strobe(5);
    rd_reg(12'h028, d); chk("R5 pos 16-bit", d, 10);
    wr_reg(12'h010, 32'h0001_0000);       // disabled
    strobe(3);
    rd_reg(12'h028, d); chk("R6 pos held", d, 10);
    wr_reg(12'h010, 32'h0000_0001);       // en, 1-byte samples
    strobe(2);
    rd_reg(12'h028, d); chk("R5 pos 8-bit", d, 12);
  endtask

  task automatic t_srst;
    logic [31:0] d;
    int waits;
    wr_reg(12'h010, 32'h0000_0002);
    #1 chk("R12 srst bit set", 32'(rdata[1]), 1);
    waits = 0;
    while (rdata[1] && waits < 100) begin
      @(negedge clk); #1 waits++;
    end
    chk("R12 srst length", 32'(waits), 8);
    rd_reg(12'h010, d); chk("R12 en cleared", 32'(d[0]), 0);
    rd_reg(12'h028, d); chk("R12 pos cleared", d, 0);
  endtask

  task automatic t_period;
    logic [31:0] d;
    wr_reg(12'h010, 32'h0004_2001);       // en, ioc irq, 4-byte samples
    strobe(47);
    rd_reg(12'h028, d); chk("R7 pos before edge", d, 188);
    rd_reg(12'h014, d); chk("R7 no flag before edge", 32'(d[31]), 0);
    strobe(1);
    rd_reg(12'h028, d); chk("R7 pos at edge", d, 192);
    rd_reg(12'h014, d); chk("R7 flag at edge", 32'(d[31]), 1);
    chk("R8 irq on", 32'(irq), 1);
    wr_reg(12'h010, 32'h0004_0001);
    #1 chk("R8 irq masked", 32'(irq), 0);
    wr_reg(12'h010, 32'h0004_2001);
    wr_reg(12'h014, 32'h0000_0000);
    rd_reg(12'h014, d); chk("R9 write 0 keeps", 32'(d[31]), 1);
    wr_reg(12'h014, 32'h8000_0000);
    rd_reg(12'h014, d); chk("R9 write 1 clears", 32'(d[31]), 0);
    chk("R8 irq after clear", 32'(irq), 0);
    strobe(48);
    rd_reg(12'h028, d); chk("R10 wrap to 0", d, 0);
    rd_reg(12'h014, d); chk("R10 flag at wrap", 32'(d[31]), 1);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    wr_reg(12'h01C, 32'h0003_0100);
    rd_reg(12'h01C, d); chk("R11 pcfg locked", d, 32'h0002_00C0);
    wr_reg(12'h010, 32'h0001_2001);
    rd_reg(12'h010, d); chk("R11 width locked", 32'(d[18:16]), 4);
    strobe(1);
    rd_reg(12'h028, d); chk("R11 step still 4", d, 4);
  endtask

  task automatic t_chsts;
    logic [31:0] d;
    chsts = 1;
    rd_reg(12'h014, d); chk("R13 chsts high", 32'(d[29]), 1);
    chsts = 0;
    rd_reg(12'h014, d); chk("R13 chsts low", 32'(d[29]), 0);
  endtask

  task automatic t_srst_flag;
    logic [31:0] d;
    wr_reg(12'h010, 32'h0000_0002);
    repeat (10) @(negedge clk);
    rd_reg(12'h014, d); chk("R12 flag cleared", 32'(d[31]), 0);
    chk("R12 irq cleared", 32'(irq), 0);
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cap();
    t_cfg();
    t_undef();
    t_step();
    t_srst();
    t_period();
    t_lock();
    t_chsts();
    t_srst_flag();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule